// File: doc/BRIEF.md
# Banked Indirect Register Access Unit

This block sits behind a management register port: a single-word write strobe with an address and data, plus a separate read address whose data returns one clock later. A few directly addressed registers give access to a hidden store of extra register banks. The hidden banks stay locked until the control register receives a fixed four-write handshake that alternates between clearing and setting a test-mode bit.

Once the banks are unlocked, each control write can carry one command. A read command copies a hidden word into the result register. A write command copies the staged data word into a hidden register. Each command names a bank and an address, and the read address and write address sit in separate fields of the command word. Writing zero to the control register locks the banks again.

Banks 0, 1 and 3 are implemented as local register storage: an analog/DSP bank, a wake/low-power bank and a self-test bank. Bank 2 has no storage.

Top module: `hreg_access`

## Requirements
- R1: The direct register map is: control register at address 20, which reads back the last value written to it; result register at address 21; staged write-data register at address 23. Any other address reads as zero. `mgmt_rdata` returns the register selected by `mgmt_raddr` one clock after that address is presented.
- R2: The command word layout is: bit 15 requests a read, bit 14 requests a write, bits 12:11 select the bank, bit 10 is test mode, bits 9:5 hold the read address and bits 4:0 hold the write address. Hidden words are 16 bits wide.
- R3: The banks unlock only after four consecutive control writes with the values 0x0000, 0x0400, 0x0000, 0x0400. A control write that breaks the sequence returns the tracker to idle. A write of 0x0000 that breaks it counts as a new first step.
- R4: While unlocked, a control write with bit 15 and bit 10 set and bit 14 clear loads the result register with the addressed hidden word. The new value is visible at address 21 on the next read.
- R5: While unlocked, a control write with bit 14 and bit 10 set and bit 15 clear stores the staged data word into the hidden register named by the bank field and bits 4:0.
- R6: A control write of 0x0000 locks the banks. A full new unlock sequence is then needed before the next command.
- R7: While locked, read and write commands change neither the result register nor any hidden register. While unlocked, a nonzero control write with bit 10 clear also locks the banks.
- R8: A command with both bit 15 and bit 14 set changes neither the result register nor any hidden register.
- R9: A read from bank 2 returns zero, and writes to bank 2 are discarded.
- R10: The result register keeps its value until the next valid read command, even if the hidden word it came from is later rewritten.
- R11: Reset clears the unlock tracker, the control, result and staged registers, and every hidden register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_we | input | 1 | Write strobe for one direct register |
| mgmt_waddr | input | 5 | Direct write address |
| mgmt_wdata | input | 16 | Direct write data |
| mgmt_raddr | input | 5 | Direct read address |
| mgmt_rdata | output | 16 | Registered read data, one clock after `mgmt_raddr` |

## Verification
The assertions assume that the management port presents at most one write per clock and that the inputs are stable across the sampling edge. The bench keeps to this by driving every input on the falling edge, one transaction at a time. The assertions also assume that the control register is the only path into the unlock tracker. The bench reaches hidden state only through the unlock, command and result registers, and it covers:
- every address of every implemented bank, written and then read back;
- bank 2;
- broken unlock sequences;
- commands issued while locked;
- commands that carry both the read and the write bit;
- a reset applied in the middle of the run.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  // Command word bit positions; the layout is fixed by the management software.
  localparam int CMD_RD_BIT   = 15;
  localparam int CMD_WR_BIT   = 14;
  localparam int CMD_BANK_HI  = 12;
  localparam int CMD_BANK_LO  = 11;
  localparam int CMD_TEST_BIT = 10;
  localparam int CMD_RA_HI    = 9;
  localparam int CMD_RA_LO    = 5;
  localparam int CMD_WA_HI    = 4;
  localparam int CMD_WA_LO    = 0;

  typedef enum logic [2:0] {
    UL_IDLE,
    UL_ZERO1,
    UL_TEST1,
    UL_ZERO2,
    UL_OPEN
  } ul_state_e;
endpackage

// File: rtl/hreg_unlock.sv
module hreg_unlock
  import hreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_val,
  output logic              open_q
);
  localparam logic [DATA_W-1:0] TEST_ONLY = DATA_W'(1) << CMD_TEST_BIT;

  ul_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (ctrl_we) begin
      if (ctrl_val == '0) begin
        st_d = (st_q == UL_TEST1) ? UL_ZERO2 : UL_ZERO1;
      end else if (ctrl_val == TEST_ONLY) begin
        case (st_q)
          UL_ZERO1: st_d = UL_TEST1;
          UL_ZERO2: st_d = UL_OPEN;
          UL_OPEN:  st_d = UL_OPEN;
          default:  st_d = UL_IDLE;
        endcase
      end else if (st_q == UL_OPEN && ctrl_val[CMD_TEST_BIT]) begin
        st_d = UL_OPEN;
      end else begin
        st_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= UL_IDLE;
    else     st_q <= st_d;
  end

  assign open_q = (st_q == UL_OPEN);

  // The tracker may enter the open state only from the second zero step, on a test-only write.
  assert_open_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == UL_OPEN && $past(st_q) != UL_OPEN) |->
      ($past(ctrl_we) && $past(ctrl_val) == TEST_ONLY && $past(st_q) == UL_ZERO2));
endmodule

// File: rtl/hreg_store.sv
module hreg_store #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int BANKS       = 4,
  parameter int UNUSED_BANK = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(BANKS)-1:0]   wbank,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [$clog2(BANKS)-1:0]   rbank,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [DATA_W-1:0]          rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_word [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    if (b != UNUSED_BANK) begin : g_impl
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && wbank == b) begin
          mem[waddr] <= wdata;
        end
      end
      assign bank_word[b] = mem[raddr];
    end else begin : g_empty
      assign bank_word[b] = '0;
    end
  end

  assign rword = bank_word[rbank];
endmodule

// File: rtl/hreg_access.sv
module hreg_access
  import hreg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int MADDR_W     = 5,
  parameter int BANKS       = 4,
  parameter int UNUSED_BANK = 2,
  parameter int CTRL_ADDR   = 20,
  parameter int RES_ADDR    = 21,
  parameter int STAGE_ADDR  = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mgmt_we,
  input  logic [MADDR_W-1:0] mgmt_waddr,
  input  logic [DATA_W-1:0]  mgmt_wdata,
  input  logic [MADDR_W-1:0] mgmt_raddr,
  output logic [DATA_W-1:0]  mgmt_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam logic [MADDR_W-1:0] CTRL_A  = MADDR_W'(CTRL_ADDR);
  localparam logic [MADDR_W-1:0] RES_A   = MADDR_W'(RES_ADDR);
  localparam logic [MADDR_W-1:0] STAGE_A = MADDR_W'(STAGE_ADDR);

  logic [DATA_W-1:0] ctrl_q, result_q, stage_q, rdata_q, rword;
  logic              ctrl_we, open_q, cmd_ok, rd_fire, wr_fire;
  logic [BANK_W-1:0] cmd_bank;

  assign ctrl_we  = mgmt_we && (mgmt_waddr == CTRL_A);
  assign cmd_bank = mgmt_wdata[CMD_BANK_HI:CMD_BANK_LO];
  assign cmd_ok   = ctrl_we && open_q && mgmt_wdata[CMD_TEST_BIT]
                    && (mgmt_wdata[CMD_RD_BIT] ^ mgmt_wdata[CMD_WR_BIT]);
  assign rd_fire  = cmd_ok && mgmt_wdata[CMD_RD_BIT];
  assign wr_fire  = cmd_ok && mgmt_wdata[CMD_WR_BIT];

  hreg_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (ctrl_we),
    .ctrl_val (mgmt_wdata),
    .open_q   (open_q)
  );

  hreg_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANKS(BANKS), .UNUSED_BANK(UNUSED_BANK)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_fire),
    .wbank (cmd_bank),
    .waddr (mgmt_wdata[CMD_WA_HI:CMD_WA_LO]),
    .wdata (stage_q),
    .rbank (cmd_bank),
    .raddr (mgmt_wdata[CMD_RA_HI:CMD_RA_LO]),
    .rword (rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      stage_q  <= '0;
      result_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= mgmt_wdata;
      if (mgmt_we && mgmt_waddr == STAGE_A) stage_q <= mgmt_wdata;
      if (rd_fire) result_q <= rword;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (mgmt_raddr)
        CTRL_A:  rdata_q <= ctrl_q;
        RES_A:   rdata_q <= result_q;
        STAGE_A: rdata_q <= stage_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign mgmt_rdata = rdata_q;

  assert_close_locks_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && mgmt_wdata == '0) |=> !open_q);

  assert_locked_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !open_q) |=> $stable(result_q));

  assert_both_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && mgmt_wdata[CMD_RD_BIT] && mgmt_wdata[CMD_WR_BIT]) |=> $stable(result_q));

  assert_bank2_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && cmd_bank == BANK_W'(UNUSED_BANK)) |=> result_q == '0);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> $past(rd_fire));
endmodule

// File: tb/test_hreg_access.sv
module test_hreg_access;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_we = 1'b0;
  logic [4:0]  mgmt_waddr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [4:0]  mgmt_raddr = '0;
  logic [15:0] mgmt_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model [4][32];

  always #10 clk = ~clk;

  hreg_access i_hreg_access (
    .clk(clk), .rst(rst), .mgmt_we(mgmt_we), .mgmt_waddr(mgmt_waddr),
    .mgmt_wdata(mgmt_wdata), .mgmt_raddr(mgmt_raddr), .mgmt_rdata(mgmt_rdata)
  );

  localparam logic [15:0] TEST = 16'h0400;

  function automatic logic [15:0] pat(int b, int a, int salt);
    return 16'((b * 16'h1111) ^ (a * 16'h0841) ^ 16'hA5C3 ^ salt);
  endfunction

  function automatic logic [15:0] cmd_rd(int b, int a);
    return 16'h8000 | 16'(b << 11) | TEST | 16'(a << 5);
  endfunction

  function automatic logic [15:0] cmd_wr(int b, int a);
    return 16'h4000 | 16'(b << 11) | TEST | 16'(a);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mwrite(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_waddr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic mread(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_raddr = a;
    @(posedge clk);
    #1 d = mgmt_rdata;
  endtask

  task automatic unlock();
    mwrite(20, 16'h0000); mwrite(20, TEST); mwrite(20, 16'h0000); mwrite(20, TEST);
  endtask

  task automatic hwrite(int b, int a, logic [15:0] d);
    unlock(); mwrite(23, d); mwrite(20, cmd_wr(b, a)); mwrite(20, 16'h0000);
    if (b != 2) model[b][a] = d;
  endtask

  task automatic hread(int b, int a, output logic [15:0] d);
    unlock(); mwrite(20, cmd_rd(b, a)); mread(21, d); mwrite(20, 16'h0000);
  endtask

  initial begin
    logic [15:0] v, last;
    for (int b = 0; b < 4; b++) for (int a = 0; a < 32; a++) model[b][a] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1/R11: reset state of direct registers
    mread(20, v); check(v == 0, "R11 ctrl reset", v, 0);
    mread(21, v); check(v == 0, "R11 result reset", v, 0);
    mread(23, v); check(v == 0, "R11 stage reset", v, 0);

    // R1: map and readback
    mwrite(23, 16'h3C5A); mread(23, v); check(v == 16'h3C5A, "R1 stage readback", v, 16'h3C5A);
    mwrite(20, TEST); mread(20, v); check(v == TEST, "R1 ctrl readback", v, TEST);
    mread(0, v); check(v == 0, "R1 unmapped", v, 0);
    mwrite(20, 16'h0000);

    // R2 R4 R5: write then read back every address of the implemented banks
    for (int b = 0; b < 4; b++) begin
      if (b == 2) continue;
      for (int a = 0; a < 32; a++) hwrite(b, a, pat(b, a, 0));
    end
    for (int b = 0; b < 4; b++) begin
      if (b == 2) continue;
      for (int a = 0; a < 32; a++) begin
        hread(b, a, v);
        check(v == model[b][a], "R4 R5 bank readback", v, model[b][a]);
      end
    end

    // R9: bank 2 discards writes and reads zero
    hwrite(2, 6, 16'hFFFF);
    hread(2, 6, v); check(v == 0, "R9 bank2 read", v, 0);
    hread(0, 6, v); check(v == model[0][6], "R9 bank2 write left bank0 intact", v, model[0][6]);
    hread(3, 6, v); check(v == model[3][6], "R9 bank2 write left bank3 intact", v, model[3][6]);

    // R6 R7: commands after a close are ignored
    hread(1, 7, last);
    mwrite(23, 16'hDEAD); mwrite(20, cmd_wr(0, 5));
    mwrite(20, cmd_rd(3, 9)); mread(21, v);
    check(v == last, "R7 read while locked", v, last);
    hread(0, 5, v); check(v == model[0][5], "R6 write after close ignored", v, model[0][5]);

    // R3: broken sequence with a nonzero step
    mwrite(20, 16'h0000); mwrite(20, TEST); mwrite(20, 16'h0001); mwrite(20, TEST);
    mwrite(23, 16'hBEEF); mwrite(20, cmd_wr(3, 9)); mwrite(20, 16'h0000);
    hread(3, 9, v); check(v == model[3][9], "R3 broken sequence write ignored", v, model[3][9]);
    // R3: a sequence stopping after three steps
    mwrite(20, 16'h0000); mwrite(20, TEST); mwrite(20, 16'h0000);
    mwrite(20, cmd_wr(3, 9)); mwrite(20, 16'h0000);
    hread(3, 9, v); check(v == model[3][9], "R3 partial sequence write ignored", v, model[3][9]);
    // R3: a repeated zero restarts the sequence
    mwrite(20, 16'h0000); mwrite(20, 16'h0000); mwrite(20, TEST); mwrite(20, 16'h0000); mwrite(20, TEST);
    mwrite(20, cmd_rd(1, 3)); mread(21, v);
    check(v == model[1][3], "R3 zero restart opens", v, model[1][3]);
    mwrite(20, 16'h0000);

    // R7: a nonzero write without test mode locks an open bank
    unlock(); mwrite(20, 16'h0001); mwrite(23, 16'h1357); mwrite(20, cmd_wr(1, 2)); mwrite(20, 16'h0000);
    hread(1, 2, v); check(v == model[1][2], "R7 no-test write locks", v, model[1][2]);

    // R8: both command bits set
    hread(0, 1, last);
    unlock(); mwrite(23, 16'h2468);
    mwrite(20, 16'hC000 | TEST | 16'(3 << 5) | 16'd3);
    mread(21, v); check(v == last, "R8 both bits result", v, last);
    mwrite(20, 16'h0000);
    hread(0, 3, v); check(v == model[0][3], "R8 both bits no store", v, model[0][3]);

    // R10: result holds after its source is rewritten
    hread(1, 4, last);
    hwrite(1, 4, 16'h0F0F);
    mread(21, v); check(v == last, "R10 result hold", v, last);

    // R11: reset clears hidden registers
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    mread(21, v); check(v == 0, "R11 result after reset", v, 0);
    hread(3, 31, v); check(v == 0, "R11 bank3 cleared", v, 0);
    hread(0, 0, v); check(v == 0, "R11 bank0 cleared", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule